// File: doc/BRIEF.md
# Wishbone Clock-Domain Crossing Bridge

This block joins a Wishbone master running on one clock to a Wishbone slave running on an unrelated clock. It carries one transaction at a time. The address, write data, byte selects and write enable cross the boundary. The read data and the acknowledge come back. Each side has its own clock and its own synchronous, active-high reset. The bridge works whether the master clock or the slave clock is the faster one.

Both ports can face pipelined-mode endpoints that use a stall signal. On the master side the bridge drives stall high whenever a cycle is open and not yet acknowledged, so a pipelined master never has a second access in flight. On the slave side, when the slave has a stall output (parameter `S_HAS_STALL`), an acknowledge counts only in a cycle where stall is low. The slave's error and retry responses are not part of the bridge. The master is only ever given a plain acknowledge.

A request leaves the master domain as a toggle of a single flop, which a two-flop synchronizer carries across. The payload is held in master-domain registers until the response toggle has returned. The master-side state machine has four states:

- `M_IDLE`: waits for an open strobe.
- `M_WAIT`: request sent. It moves to `M_ACK` when the response returns while cyc is high, and to `M_DROP` if cyc falls.
- `M_ACK`: a one-cycle acknowledge, then back to `M_IDLE`.
- `M_DROP`: waits out an abandoned access, then returns to `M_IDLE` without an acknowledge.

The slave-side state machine has three states:

- `S_IDLE`: waits for a new request toggle.
- `S_BUSY`: cyc and stb high until an accepted acknowledge. The read data is captured and the response toggle flips.
- `S_GAP`: one cycle with the strobes low, then back to `S_IDLE`.

Top module: `wb_cdc_bridge`

## Requirements
- R1: `m_stall` is high exactly while `m_cyc` is high and `m_ack` is low, so it is high for every cycle a master access waits and low while no cycle is open.
- R2: Each completed master access gets exactly one `m_ack` pulse, one master clock long.
- R3: Every master write reaches the slave exactly once, with the requested address, data, select and write enable. The slave applies byte lane k (bits 8k+7..8k) only where select bit k is set.
- R4: A master read returns, on `m_dat_r` in the cycle `m_ack` is high, the slave's `s_dat_r` from the cycle in which the slave acknowledge was accepted.
- R5: With `S_HAS_STALL`=1, a slave acknowledge is accepted only in a cycle where `s_stall` is low. An `s_ack` raised together with `s_stall` completes nothing.
- R6: While `s_stb` is high and no acknowledge has been accepted, `s_stb`, `s_cyc`, `s_adr`, `s_dat_w`, `s_sel` and `s_we` stay unchanged.
- R7: After an accepted slave acknowledge, `s_stb` and `s_cyc` are low for at least the next slave cycle.
- R8: If the master drops `m_cyc` before its acknowledge, the slave access still completes once and no `m_ack` is given for it. The next master access then completes correctly. `m_ack` is only raised after a cycle in which `m_cyc` was high.
- R9: After reset, `m_ack`, `m_stall`, `s_cyc` and `s_stb` are low.
- R10: R2 to R8 hold both with the slave clock faster than the master clock and with it slower.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| m_clk | input | 1 | Master-side clock |
| m_rst | input | 1 | Master-side synchronous reset, active high |
| m_cyc | input | 1 | Master cycle valid |
| m_stb | input | 1 | Master strobe |
| m_we | input | 1 | Master write enable |
| m_adr | input | AW | Master address |
| m_dat_w | input | DW | Master write data |
| m_sel | input | DW/8 | Master byte selects |
| m_ack | output | 1 | Acknowledge to master |
| m_stall | output | 1 | Stall to master (cyc and not ack) |
| m_dat_r | output | DW | Read data to master |
| s_clk | input | 1 | Slave-side clock |
| s_rst | input | 1 | Slave-side synchronous reset, active high |
| s_cyc | output | 1 | Slave cycle valid |
| s_stb | output | 1 | Slave strobe |
| s_we | output | 1 | Slave write enable |
| s_adr | output | AW | Slave address |
| s_dat_w | output | DW | Slave write data |
| s_sel | output | DW/8 | Slave byte selects |
| s_ack | input | 1 | Slave acknowledge |
| s_stall | input | 1 | Slave stall (used when S_HAS_STALL=1) |
| s_dat_r | input | DW | Slave read data |

## Verification
Two things can meet in a single slave cycle: the slave raising its acknowledge and the slave still holding stall high. Only the second must win. The slave model raises ack together with stall on some cycles, chosen by a free-running pseudo-random pattern. A false acceptance shows up as a missing write count or a wrong read value, and it is judged against a shadow memory. On the master side, abandoning a cycle can coincide with the response coming home. Aborts issued at once after a request provoke this, and any acknowledge outside an open access is counted as a failure.

// File: rtl/wbb_pkg.sv
package wbb_pkg;

    typedef enum logic [1:0] {
        M_IDLE,
        M_WAIT,
        M_ACK,
        M_DROP
    } m_state_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_BUSY,
        S_GAP
    } s_state_e;

endpackage

// File: rtl/wbb_sync.sv
module wbb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/wbb_master_side.sv
module wbb_master_side
    import wbb_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int SW = DW / 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cyc,
    input  logic          stb,
    input  logic          we,
    input  logic [AW-1:0] adr,
    input  logic [DW-1:0] dat_w,
    input  logic [SW-1:0] sel,
    output logic          ack,
    output logic          stall,
    output logic [DW-1:0] dat_r,
    output logic          req_tgl,
    output logic [AW-1:0] hold_adr,
    output logic [DW-1:0] hold_dat,
    output logic [SW-1:0] hold_sel,
    output logic          hold_we,
    input  logic          rsp_tgl_sync,
    input  logic [DW-1:0] rsp_dat
);
    m_state_e st, nxt;
    logic     returned;

    // The response has come home when the synchronized toggle matches ours
    assign returned = (rsp_tgl_sync == req_tgl);

    always_ff @(posedge clk) begin
        if (rst) st <= M_IDLE;
        else     st <= nxt;
    end

    always_comb begin
        nxt = st;
        unique case (st)
            M_IDLE: if (cyc && stb) nxt = M_WAIT;
            M_WAIT: begin
                if (!cyc)          nxt = M_DROP;
                else if (returned) nxt = M_ACK;
            end
            M_ACK:  nxt = M_IDLE;
            M_DROP: if (returned) nxt = M_IDLE;
            default: nxt = M_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_tgl  <= 1'b0;
            hold_adr <= '0;
            hold_dat <= '0;
            hold_sel <= '0;
            hold_we  <= 1'b0;
            dat_r    <= '0;
        end else begin
            if (st == M_IDLE && cyc && stb) begin
                hold_adr <= adr;
                hold_dat <= dat_w;
                hold_sel <= sel;
                hold_we  <= we;
                req_tgl  <= ~req_tgl;
            end
            if (st == M_WAIT && nxt == M_ACK) dat_r <= rsp_dat;
        end
    end

    assign ack   = (st == M_ACK);
    assign stall = cyc & ~ack;
endmodule

// File: rtl/wbb_slave_side.sv
module wbb_slave_side
    import wbb_pkg::*;
#(
    parameter int DW        = 32,
    parameter bit HAS_STALL = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_tgl_sync,
    output logic          rsp_tgl,
    output logic [DW-1:0] rd_dat,
    output logic          cyc,
    output logic          stb,
    input  logic          ack,
    input  logic          stall,
    input  logic [DW-1:0] dat_r
);
    s_state_e st, nxt;
    logic     seen;
    logic     accepted;

    generate
        if (HAS_STALL) begin : g_qual
            assign accepted = ack & ~stall;
        end else begin : g_raw
            assign accepted = ack;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) st <= S_IDLE;
        else     st <= nxt;
    end

    always_comb begin
        nxt = st;
        unique case (st)
            S_IDLE: if (req_tgl_sync != seen) nxt = S_BUSY;
            S_BUSY: if (accepted) nxt = S_GAP;
            S_GAP:  nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seen    <= 1'b0;
            rsp_tgl <= 1'b0;
            rd_dat  <= '0;
        end else begin
            if (st == S_IDLE && req_tgl_sync != seen) seen <= req_tgl_sync;
            if (st == S_BUSY && accepted) begin
                rd_dat  <= dat_r;
                rsp_tgl <= ~rsp_tgl;
            end
        end
    end

    assign cyc = (st == S_BUSY);
    assign stb = (st == S_BUSY);
endmodule

// File: rtl/wb_cdc_bridge.sv
module wb_cdc_bridge #(
    parameter int   AW          = 32,
    parameter int   DW          = 32,
    parameter int   SYNC_STAGES = 2,
    parameter bit   S_HAS_STALL = 1'b1,
    localparam int  SW          = DW / 8
) (
    input  logic          m_clk,
    input  logic          m_rst,
    input  logic          m_cyc,
    input  logic          m_stb,
    input  logic          m_we,
    input  logic [AW-1:0] m_adr,
    input  logic [DW-1:0] m_dat_w,
    input  logic [SW-1:0] m_sel,
    output logic          m_ack,
    output logic          m_stall,
    output logic [DW-1:0] m_dat_r,
    input  logic          s_clk,
    input  logic          s_rst,
    output logic          s_cyc,
    output logic          s_stb,
    output logic          s_we,
    output logic [AW-1:0] s_adr,
    output logic [DW-1:0] s_dat_w,
    output logic [SW-1:0] s_sel,
    input  logic          s_ack,
    input  logic          s_stall,
    input  logic [DW-1:0] s_dat_r
);
    logic          req_tgl, req_tgl_s;
    logic          rsp_tgl, rsp_tgl_m;
    logic [DW-1:0] rd_dat;

    wbb_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk(s_clk), .rst(s_rst), .d(req_tgl), .q(req_tgl_s)
    );

    wbb_sync #(.STAGES(SYNC_STAGES)) u_rsp_sync (
        .clk(m_clk), .rst(m_rst), .d(rsp_tgl), .q(rsp_tgl_m)
    );

    wbb_master_side #(.AW(AW), .DW(DW), .SW(SW)) u_mside (
        .clk(m_clk), .rst(m_rst),
        .cyc(m_cyc), .stb(m_stb), .we(m_we), .adr(m_adr),
        .dat_w(m_dat_w), .sel(m_sel),
        .ack(m_ack), .stall(m_stall), .dat_r(m_dat_r),
        .req_tgl(req_tgl),
        .hold_adr(s_adr), .hold_dat(s_dat_w), .hold_sel(s_sel), .hold_we(s_we),
        .rsp_tgl_sync(rsp_tgl_m), .rsp_dat(rd_dat)
    );

    wbb_slave_side #(.DW(DW), .HAS_STALL(S_HAS_STALL)) u_sside (
        .clk(s_clk), .rst(s_rst),
        .req_tgl_sync(req_tgl_s), .rsp_tgl(rsp_tgl), .rd_dat(rd_dat),
        .cyc(s_cyc), .stb(s_stb),
        .ack(s_ack), .stall(s_stall), .dat_r(s_dat_r)
    );
endmodule

// File: rtl/wbb_checker.sv
module wbb_checker #(
    parameter int AW        = 32,
    parameter int DW        = 32,
    parameter int SW        = DW / 8,
    parameter bit HAS_STALL = 1'b1
) (
    input logic          m_clk,
    input logic          m_rst,
    input logic          m_cyc,
    input logic          m_ack,
    input logic          m_stall,
    input logic          s_clk,
    input logic          s_rst,
    input logic          s_cyc,
    input logic          s_stb,
    input logic          s_we,
    input logic [AW-1:0] s_adr,
    input logic [DW-1:0] s_dat_w,
    input logic [SW-1:0] s_sel,
    input logic          s_ack,
    input logic          s_stall
);
    logic acc;
    always_comb acc = s_ack && (!HAS_STALL || !s_stall);

    p_stall_cyc_r1: assert property (@(posedge m_clk) disable iff (m_rst)
        m_stall |-> m_cyc);

    p_ack_pulse_r2: assert property (@(posedge m_clk) disable iff (m_rst)
        m_ack |=> !m_ack);

    p_ack_after_cyc_r8: assert property (@(posedge m_clk) disable iff (m_rst)
        m_ack |-> $past(m_cyc));

    p_hold_r6: assert property (@(posedge s_clk) disable iff (s_rst)
        (s_stb && !acc) |=> (s_stb && s_cyc && $stable(s_adr) && $stable(s_dat_w)
                              && $stable(s_sel) && $stable(s_we)));

    p_gap_r7: assert property (@(posedge s_clk) disable iff (s_rst)
        (s_stb && acc) |=> (!s_stb && !s_cyc));
endmodule

bind wb_cdc_bridge wbb_checker #(
    .AW(AW), .DW(DW), .SW(SW), .HAS_STALL(S_HAS_STALL)
) u_chk (
    .m_clk(m_clk), .m_rst(m_rst), .m_cyc(m_cyc), .m_ack(m_ack), .m_stall(m_stall),
    .s_clk(s_clk), .s_rst(s_rst), .s_cyc(s_cyc), .s_stb(s_stb), .s_we(s_we),
    .s_adr(s_adr), .s_dat_w(s_dat_w), .s_sel(s_sel), .s_ack(s_ack), .s_stall(s_stall)
);

// File: tb/wb_cdc_bridge_test.sv
`timescale 1ns/1ps
module wb_cdc_bridge_test;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int SW = DW / 8;

    logic          m_clk = 0, m_rst = 1, s_clk = 0, s_rst = 1;
    logic          m_cyc = 0, m_stb = 0, m_we = 0;
    logic [AW-1:0] m_adr = '0;
    logic [DW-1:0] m_dat_w = '0;
    logic [SW-1:0] m_sel = '0;
    logic          m_ack, m_stall;
    logic [DW-1:0] m_dat_r;
    logic          s_cyc, s_stb, s_we;
    logic [AW-1:0] s_adr;
    logic [DW-1:0] s_dat_w;
    logic [SW-1:0] s_sel;
    logic          s_ack = 0, s_stall = 0;
    logic [DW-1:0] s_dat_r = '0;

    int  checks = 0, fails = 0;
    real s_half = 1.7;
    bit  done = 0;

    wb_cdc_bridge #(.AW(AW), .DW(DW)) uut (.*);

    always #2 m_clk = ~m_clk;
    initial forever #(s_half) s_clk = ~s_clk;

    // Slave memory model: 16 words decoded from s_adr[3:0]
    logic [DW-1:0] mem [16];
    int            wr_cnt [16];
    logic [7:0]    lfsr = 8'h5a;
    logic          pend = 0;
    logic [AW-1:0] pend_adr;
    logic [DW-1:0] pend_dat;

    initial for (int i = 0; i < 16; i++) begin mem[i] = '0; wr_cnt[i] = 0; end

    always @(posedge s_clk) begin
        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        if (s_rst) begin
            s_ack <= 0; s_stall <= 0; pend <= 0;
        end else if (s_stb && s_ack && !s_stall) begin
            if (s_we) begin
                for (int b = 0; b < SW; b++)
                    if (s_sel[b]) mem[s_adr[3:0]][8*b +: 8] <= s_dat_w[8*b +: 8];
                wr_cnt[s_adr[3:0]] <= wr_cnt[s_adr[3:0]] + 1;
            end
            s_ack <= 0; s_stall <= 0; pend <= 0;
        end else if (s_stb) begin
            if (pend && (s_adr != pend_adr || s_dat_w != pend_dat)) begin
                fails++;
                $display("FAIL R6 request changed while waiting: adr %h/%h dat %h/%h",
                         s_adr, pend_adr, s_dat_w, pend_dat);
            end
            pend <= 1; pend_adr <= s_adr; pend_dat <= s_dat_w;
            case (lfsr[1:0])
                2'd0: begin s_ack <= 0; s_stall <= 1; end
                2'd1: begin s_ack <= 1; s_stall <= 1; end
                default: begin s_ack <= 1; s_stall <= 0; s_dat_r <= mem[s_adr[3:0]]; end
            endcase
        end else begin
            s_ack <= 0; s_stall <= 0; pend <= 0;
        end
    end

    // Scoreboard
    logic [DW-1:0] exp_q [$];
    logic [DW-1:0] shadow [16];
    int            exp_wr [16];
    bit            active = 0, cur_we = 0, got_ack = 0, prev_ack = 0, stall_ok = 1;
    bit            mon_on = 0;

    initial for (int i = 0; i < 16; i++) begin shadow[i] = '0; exp_wr[i] = 0; end

    always @(posedge m_clk) begin
        #1;
        if (mon_on) begin
            if (active && !m_ack && !m_stall) stall_ok = 0;
            if (m_ack && prev_ack) begin
                fails++; $display("FAIL R2 ack longer than one cycle: got 1 expected 0");
            end
            if (m_ack && !active) begin
                fails++; $display("FAIL R8 ack with no open access: got 1 expected 0");
            end
            if (m_ack && active && !got_ack) begin
                got_ack = 1;
                if (!cur_we) begin
                    logic [DW-1:0] e;
                    e = exp_q.pop_front();
                    checks++;
                    if (m_dat_r !== e) begin
                        fails++;
                        $display("FAIL R4/R10 read data got %h expected %h", m_dat_r, e);
                    end
                end
            end
        end
        prev_ack = m_ack;
    end

    task automatic txn(input bit we, input logic [3:0] a, input logic [DW-1:0] d,
                       input logic [SW-1:0] sel);
        int n;
        @(negedge m_clk);
        m_cyc = 1; m_stb = 1; m_we = we; m_adr = {28'h0, a}; m_dat_w = d; m_sel = sel;
        if (we) begin
            for (int b = 0; b < SW; b++) if (sel[b]) shadow[a][8*b +: 8] = d[8*b +: 8];
            exp_wr[a]++;
        end else exp_q.push_back(shadow[a]);
        cur_we = we; active = 1; got_ack = 0; stall_ok = 1;
        n = 0;
        while (!got_ack && n < 5000) begin @(negedge m_clk); n++; end
        checks++;
        if (!got_ack) begin fails++; $display("FAIL R2 no ack: got 0 expected 1"); end
        checks++;
        if (!stall_ok) begin fails++; $display("FAIL R1 stall low while waiting: got 0 expected 1"); end
        m_cyc = 0; m_stb = 0; active = 0;
        @(negedge m_clk);
        checks++;
        if (m_ack !== 1'b0 || m_stall !== 1'b0) begin
            fails++; $display("FAIL R1/R2 after access ack=%b stall=%b expected 0/0", m_ack, m_stall);
        end
    endtask

    task automatic abort_txn(input bit we, input logic [3:0] a, input logic [DW-1:0] d);
        @(negedge m_clk);
        m_cyc = 1; m_stb = 1; m_we = we; m_adr = {28'h0, a}; m_dat_w = d; m_sel = '1;
        if (we) begin shadow[a] = d; exp_wr[a]++; end
        @(negedge m_clk);
        m_cyc = 0; m_stb = 0;
        // any ack from here is flagged by the monitor as R8
    endtask

    task automatic run_phase(input logic [DW-1:0] seed);
        for (int i = 0; i < 16; i++) txn(1, i[3:0], seed ^ (i * 32'h01010101), '1);
        for (int i = 0; i < 16; i++) txn(0, i[3:0], '0, '0);
        txn(1, 4'd3, 32'hAABBCCDD, 4'b0101);
        txn(0, 4'd3, '0, '0);
        txn(1, 4'd3, 32'h11223344, 4'b1000);
        txn(1, 4'd3, 32'h55667788, 4'b0010);
        txn(0, 4'd3, '0, '0);
        abort_txn(1, 4'd7, seed + 32'd77);
        txn(0, 4'd7, '0, '0);
        abort_txn(0, 4'd2, '0);
        txn(0, 4'd2, '0, '0);
        abort_txn(1, 4'd9, seed + 32'd99);
        repeat (40) @(negedge m_clk);
        txn(0, 4'd9, '0, '0);
    endtask

    initial begin
        repeat (4) @(negedge m_clk);
        m_rst = 0; s_rst = 0;
        @(negedge m_clk);
        checks++;
        if (m_ack !== 0 || m_stall !== 0 || s_cyc !== 0 || s_stb !== 0) begin
            fails++;
            $display("FAIL R9 reset state ack=%b stall=%b cyc=%b stb=%b expected 0000",
                     m_ack, m_stall, s_cyc, s_stb);
        end
        mon_on = 1;
        // slave clock faster than master clock
        run_phase(32'hC0DE0000);
        // slave clock slower than master clock (R10)
        s_half = 5.3;
        repeat (10) @(negedge m_clk);
        run_phase(32'h0BADF00D);
        repeat (60) @(negedge m_clk);
        for (int i = 0; i < 16; i++) begin
            checks++;
            if (wr_cnt[i] != exp_wr[i]) begin
                fails++;
                $display("FAIL R3/R5/R8 write count addr %0d got %0d expected %0d", i, wr_cnt[i], exp_wr[i]);
            end
            checks++;
            if (mem[i] !== shadow[i]) begin
                fails++;
                $display("FAIL R3 memory addr %0d got %h expected %h", i, mem[i], shadow[i]);
            end
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(190000 * 4);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired: got hang expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule